// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block turns the system clock into the bit timing for a serial transceiver. A down-counting prescaler runs for (divisor + 1) system cycles per expiry and reloads itself. A post-divider then counts prescaler expiries and emits a one-cycle bit tick at a rate set by the operating mode. It also emits a receiver sample tick and, when the block is the clock master, a serial clock output. In the external-clock mode the post-divider is bypassed: the serial clock pin is passed through a synchronizer, and its edges become the ticks.

The operating mode is a small state register, `baud_mode_e`, decoded every cycle from three inputs. The states are MODE_ASYNC_NORM, MODE_ASYNC_DBL, MODE_SYNC_MST and MODE_SYNC_SLV. Any state may move to any other when the inputs change, and every such transition restarts the prescaler and the post-divider. A change of divisor value is a restart transition back into the same state. With no change, each state holds itself.

Top module: `baud_gen_top`

## Requirements
- R1: The prescaler expires once every (div_val + 1) cycles for div_val in 0..4095. A change of div_val restarts the timing, so the first bit tick follows the change by exactly (bit-rate factor) x (new div_val + 1) cycles.
- R2: With mode_sync=0 and dbl_speed=0 (MODE_ASYNC_NORM), baud_tick has period 16*(div_val+1) and samp_tick pulses 16 times per bit, once in the baud_tick cycle.
- R3: With mode_sync=0 and dbl_speed=1 (MODE_ASYNC_DBL), baud_tick has period 8*(div_val+1) and samp_tick pulses 8 times per bit.
- R4: With mode_sync=1 and xck_dir=1 (MODE_SYNC_MST), baud_tick has period 2*(div_val+1), samp_tick equals baud_tick, and xck_out toggles on every prescaler expiry, reading 1 in the cycle of each baud_tick.
- R5: dbl_speed has no effect in either synchronous mode, and xck_dir has no effect in the asynchronous modes.
- R6: With mode_sync=1 and xck_dir=0 (MODE_SYNC_SLV), a rising edge of xck_in produces a one-cycle baud_tick and a falling edge a one-cycle samp_tick. The tick is high in the cycle after the second rising clock edge that samples the new level.
- R7: xck_out is 0 from the cycle after any cycle in which the inputs do not select MODE_SYNC_MST.
- R8: While rst_n is low and div_val is nonzero, baud_tick, samp_tick and xck_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 12 | Prescaler divisor; prescale is div_val + 1 |
| mode_sync | input | 1 | 1 selects synchronous operation |
| dbl_speed | input | 1 | Halves the asynchronous bit-rate factor (16 to 8) |
| xck_dir | input | 1 | In synchronous operation, 1 drives the serial clock, 0 follows xck_in |
| xck_in | input | 1 | External serial clock |
| baud_tick | output | 1 | One-cycle bit-rate enable |
| samp_tick | output | 1 | One-cycle receiver sample enable |
| xck_out | output | 1 | Generated serial clock (master mode) |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor and a two-stage synchronizer. The full divisor range is therefore reachable, and periods are measured at div_val = 0 and at div_val = 4095 in the double-speed and master modes. The fixed synchronizer depth makes the two-cycle external-edge latency an exact cycle count. Short divisors keep the per-bit sample count and the restart timing cheap to check in every mode.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PH_W = 4;

    typedef enum logic [1:0] {
        MODE_ASYNC_NORM = 2'd0,
        MODE_ASYNC_DBL  = 2'd1,
        MODE_SYNC_MST   = 2'd2,
        MODE_SYNC_SLV   = 2'd3
    } baud_mode_e;

    // Map the three select inputs onto an operating mode.
    function automatic baud_mode_e decode_mode(input logic sync_sel,
                                               input logic dbl,
                                               input logic dir);
        if (!sync_sel)
            return dbl ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
        return dir ? MODE_SYNC_MST : MODE_SYNC_SLV;
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || cnt_q == '0)
            cnt_q <= div_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0) && !restart;

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  baud_mode_e mode,
    input  logic       presc_tick,
    output logic       bit_tick,
    output logic       smp_tick,
    output logic       clk_out
);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] last_ph;
    logic            wrap;

    always_comb begin
        unique case (mode)
            MODE_ASYNC_NORM: last_ph = PH_W'(15);
            MODE_ASYNC_DBL:  last_ph = PH_W'(7);
            MODE_SYNC_MST:   last_ph = PH_W'(1);
            MODE_SYNC_SLV:   last_ph = PH_W'(0);
        endcase
    end

    assign wrap = (phase_q == last_ph);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (presc_tick)
            phase_q <= wrap ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            clk_out <= 1'b0;
        else if (restart || mode != MODE_SYNC_MST)
            clk_out <= 1'b0;
        else if (presc_tick)
            clk_out <= ~clk_out;
    end

    assign bit_tick = presc_tick && wrap;

    always_comb begin
        unique case (mode)
            MODE_ASYNC_NORM,
            MODE_ASYNC_DBL:  smp_tick = presc_tick;
            MODE_SYNC_MST,
            MODE_SYNC_SLV:   smp_tick = bit_tick;
        endcase
    end

endmodule

// File: rtl/baud_xck_sync.sv
module baud_xck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q[0] <= 1'b0;
        else
            chain_q[0] <= pin;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain_q[g] <= 1'b0;
            else
                chain_q[g] <= chain_q[g-1];
        end
    end

    assign rise =  chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall = !chain_q[STAGES-1] &&  chain_q[STAGES];

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import baud_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             mode_sync,
    input  logic             dbl_speed,
    input  logic             xck_dir,
    input  logic             xck_in,
    output logic             baud_tick,
    output logic             samp_tick,
    output logic             xck_out
);

    baud_mode_e       state_q;
    baud_mode_e       state_d;
    logic [DIV_W-1:0] div_q;
    logic             restart;
    logic             presc_tick;
    logic             pd_bit;
    logic             pd_smp;
    logic             ext_rise;
    logic             ext_fall;

    assign state_d = decode_mode(mode_sync, dbl_speed, xck_dir);
    assign restart = (state_d != state_q) || (div_val != div_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_ASYNC_NORM;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= div_val;
        end
    end

    baud_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_val (div_val),
        .tick    (presc_tick)
    );

    baud_postdiv u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .mode       (state_q),
        .presc_tick (presc_tick),
        .bit_tick   (pd_bit),
        .smp_tick   (pd_smp),
        .clk_out    (xck_out)
    );

    baud_xck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (xck_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    always_comb begin
        unique case (state_q)
            MODE_SYNC_SLV: begin
                baud_tick = ext_rise && !restart;
                samp_tick = ext_fall && !restart;
            end
            MODE_ASYNC_NORM,
            MODE_ASYNC_DBL,
            MODE_SYNC_MST: begin
                baud_tick = pd_bit;
                samp_tick = pd_smp;
            end
        endcase
    end

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_val,
    input logic             mode_sync,
    input logic             dbl_speed,
    input logic             xck_dir,
    input logic             xck_in,
    input logic             baud_tick,
    input logic             samp_tick,
    input logic             xck_out
);

    logic [DIV_W-1:0] div_seen;
    logic [2:0]       sel_seen;
    logic [4:0]       smp_cnt;
    logic             cfg_chg;
    logic             is_mst;
    logic             is_slv;

    assign is_mst  = mode_sync && xck_dir;
    assign is_slv  = mode_sync && !xck_dir;
    assign cfg_chg = (div_val != div_seen)
                  || ({mode_sync, dbl_speed, xck_dir} != sel_seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_seen <= '0;
            sel_seen <= 3'b000;
            smp_cnt  <= '0;
        end else begin
            div_seen <= div_val;
            sel_seen <= {mode_sync, dbl_speed, xck_dir};
            if (cfg_chg || baud_tick)
                smp_cnt <= '0;
            else if (samp_tick)
                smp_cnt <= smp_cnt + 1'b1;
        end
    end

    // R2
    norm_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && !dbl_speed && !cfg_chg && baud_tick) |-> (samp_tick && smp_cnt == 5'd15));

    // R3
    dbl_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && dbl_speed && !cfg_chg && baud_tick) |-> (samp_tick && smp_cnt == 5'd7));

    // R4
    mst_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mst && !cfg_chg && baud_tick) |-> (samp_tick && xck_out));

    // R7
    xck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mst |=> !xck_out);

    // R6
    slv_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slv && baud_tick) |-> ($past(xck_in, 2) && !$past(xck_in, 3)));

endmodule

bind baud_gen_top baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_val   (div_val),
    .mode_sync (mode_sync),
    .dbl_speed (dbl_speed),
    .xck_dir   (xck_dir),
    .xck_in    (xck_in),
    .baud_tick (baud_tick),
    .samp_tick (samp_tick),
    .xck_out   (xck_out)
);

// File: tb/baud_gen_top_test.sv
module baud_gen_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_val = 12'd0;
    logic        mode_sync = 1'b0;
    logic        dbl_speed = 1'b0;
    logic        xck_dir = 1'b0;
    logic        xck_in = 1'b0;
    logic        baud_tick;
    logic        samp_tick;
    logic        xck_out;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int    period;
        int    samples;
        bit    mst;
        string req;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    baud_gen_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_val   (div_val),
        .mode_sync (mode_sync),
        .dbl_speed (dbl_speed),
        .xck_dir   (xck_dir),
        .xck_in    (xck_in),
        .baud_tick (baud_tick),
        .samp_tick (samp_tick),
        .xck_out   (xck_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each bit interval and compares with the queue front.
    int since = 0;
    int samps = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since++;
            if (samp_tick) samps++;
            if (baud_tick) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(since == e.period, {e.req, " period"}, since, e.period);
                    check(samps == e.samples, {e.req, " samples"}, samps, e.samples);
                    if (e.mst) check(xck_out == 1'b1, {e.req, " xck_out"}, int'(xck_out), 1);
                end
                since = 0;
                samps = 0;
            end
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!baud_tick);
    endtask

    // Driver: apply a configuration, skip the first bit, queue expectations.
    task automatic run_cfg(input bit s, input bit d, input bit r, input int dv,
                           input int factor, input int nsmp, input int n, input string req);
        @(negedge clk);
        mode_sync = s; dbl_speed = d; xck_dir = r; div_val = 12'(dv);
        wait_tick();
        @(posedge clk);
        for (int i = 0; i < n; i++)
            q.push_back('{factor * (dv + 1), nsmp, s && r, req});
        while (q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R8: reset state
        div_val = 12'd7;
        repeat (3) @(negedge clk);
        check(baud_tick == 1'b0 && samp_tick == 1'b0 && xck_out == 1'b0,
              "R8 reset outputs", int'({baud_tick, samp_tick, xck_out}), 0);
        rst_n = 1'b1;

        // R2: normal asynchronous
        run_cfg(0, 0, 0, 0,   16, 16, 3, "R2 d0");
        run_cfg(0, 0, 0, 5,   16, 16, 2, "R2 d5");
        run_cfg(0, 0, 0, 100, 16, 16, 2, "R2 d100");
        // R3: double speed
        run_cfg(0, 1, 0, 0,    8, 8, 2, "R3 d0");
        run_cfg(0, 1, 0, 9,    8, 8, 2, "R3 d9");
        run_cfg(0, 1, 0, 4095, 8, 8, 1, "R3 d4095");
        // R4: synchronous master
        run_cfg(1, 0, 1, 0,    2, 1, 3, "R4 d0");
        run_cfg(1, 0, 1, 1,    2, 1, 2, "R4 d1");
        run_cfg(1, 0, 1, 4095, 2, 1, 1, "R4 d4095");
        // R5: ignored flags
        run_cfg(1, 1, 1, 3, 2, 1, 2, "R5 dbl in master");
        run_cfg(0, 1, 1, 2, 8, 8, 2, "R5 dir in async");
        check(xck_out == 1'b0, "R7 xck_out async", int'(xck_out), 0);

        // R1: divisor change restarts timing (8 * 4 = 32 cycles)
        run_cfg(0, 1, 0, 200, 8, 8, 0, "R1 setup");
        repeat (50) @(negedge clk);
        div_val = 12'd3;
        begin
            int first = 0;
            for (int i = 1; i <= 40 && first == 0; i++) begin
                @(negedge clk);
                if (baud_tick) first = i;
            end
            check(first == 32, "R1 restart latency", first, 32);
        end

        // R6: slave edge latency
        mode_sync = 1'b1; xck_dir = 1'b0; dbl_speed = 1'b1; xck_in = 1'b0;
        repeat (6) @(negedge clk);
        check(xck_out == 1'b0, "R7 xck_out slave", int'(xck_out), 0);
        xck_in = 1'b1;
        @(negedge clk);
        check(baud_tick == 1'b0, "R6 rise early", int'(baud_tick), 0);
        @(negedge clk);
        check(baud_tick == 1'b1, "R6 rise tick", int'(baud_tick), 1);
        @(negedge clk);
        check(baud_tick == 1'b0, "R6 rise one cycle", int'(baud_tick), 0);
        repeat (3) @(negedge clk);
        xck_in = 1'b0;
        @(negedge clk);
        check(samp_tick == 1'b0, "R6 fall early", int'(samp_tick), 0);
        @(negedge clk);
        check(samp_tick == 1'b1 && baud_tick == 1'b0, "R6 fall tick",
              int'({samp_tick, baud_tick}), 2);
        @(negedge clk);
        check(samp_tick == 1'b0, "R6 fall one cycle", int'(samp_tick), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule